// File: doc/BRIEF.md
# Single-Cycle Load-Store Processor Core

This block is a 32-bit processor core that completes one instruction per clock. It fetches a word from a small internal instruction memory at the program counter, decodes it into datapath selects, reads up to two of 32 general registers, runs the ALU, optionally touches a small internal word-addressed data memory, and writes at most one register before the next rising edge. The supported operations are register-register add, subtract, AND, OR and signed set-less-than; add-immediate; word load and word store; and branch-on-equal and branch-on-not-equal.

Both memories are filled from outside through a single write port while the core is held in reset. A pair of observation ports reads back any register and any data word, so a program's results can be inspected once it reaches a self-branch that parks the program counter.

Top module: `sc_core`

## Requirements
- R1: While rst_ni is low the program counter reads 0 and every register reads 0; the first instruction executed after release is the one at word 0.
- R2: Opcode 0 selects a register-register operation chosen by the low six bits: 0x20 add, 0x22 subtract (rs minus rt), 0x24 AND, 0x25 OR, 0x2A signed set-less-than (result 1 or 0); the result goes to the register named by bits [15:11].
- R3: Opcode 0x08 adds the sign-extended bits [15:0] to rs and writes the register named by bits [20:16].
- R4: Opcode 0x23 reads the data word at byte address rs plus the sign-extended immediate (word index = address bits [7:2]) and writes it to the register named by bits [20:16].
- R5: Opcode 0x2B writes the value of the register named by bits [20:16] to the data word at rs plus the sign-extended immediate and changes no register.
- R6: Opcode 0x04 compares rs and rt; when equal the next PC is PC+4 plus the sign-extended immediate times 4, otherwise PC+4.
- R7: Opcode 0x05 takes the same target when rs and rt differ, otherwise PC+4.
- R8: Register 0 always reads as zero; writes naming it are discarded.
- R9: Every instruction that is not a taken branch advances the PC by exactly 4.
- R10: An unknown opcode, or opcode 0 with an unknown function code, changes no register and no data word.
- R11: With ld_imem_we_i or ld_dmem_we_i high, ld_data_i is written at a rising edge to word ld_addr_i of the instruction or data memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ld_imem_we_i | input | 1 | Load strobe for instruction memory |
| ld_dmem_we_i | input | 1 | Load strobe for data memory |
| ld_addr_i | input | 6 | Word index for a load write |
| ld_data_i | input | 32 | Word to load |
| dbg_reg_addr_i | input | 5 | Register to observe |
| dbg_reg_data_o | output | 32 | Value of the observed register |
| dbg_mem_addr_i | input | 6 | Data word to observe |
| dbg_mem_data_o | output | 32 | Value of the observed data word |
| pc_o | output | 32 | Current program counter |

## Verification
A wrong decode or ALU select shows as a wrong register value after the one cycle that instruction occupies, and because later instructions consume that value the error spreads into the stored words and the final register image. A wrong branch condition or target shows on pc_o in the very next cycle and also leaves skipped or repeated writes visible in the register image. Sweeping operand pairs across sign and overflow boundaries makes each ALU function and each select meet the values most likely to expose a swapped or missing path.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN = 32;

  typedef enum logic [5:0] {
    OP_RTYPE = 6'h00,
    OP_BEQ   = 6'h04,
    OP_BNE   = 6'h05,
    OP_ADDI  = 6'h08,
    OP_LW    = 6'h23,
    OP_SW    = 6'h2B
  } opcode_e;

  typedef enum logic [5:0] {
    FN_ADD = 6'h20,
    FN_SUB = 6'h22,
    FN_AND = 6'h24,
    FN_OR  = 6'h25,
    FN_SLT = 6'h2A
  } funct_e;

  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111
  } alu_op_e;

  typedef struct packed {
    logic    reg_write;
    logic    reg_dst;     // 1: rd [15:11], 0: rt [20:16]
    logic    alu_src;     // 1: sign-extended immediate
    logic    mem_to_reg;
    logic    mem_read;
    logic    mem_write;
    logic    branch;
    logic    br_ne;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
  import sc_pkg::*;
(
  input  logic [5:0] opcode_i,
  input  logic [5:0] funct_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o = '{default: '0, alu_op: ALU_ADD};
    case (opcode_i)
      OP_RTYPE: begin
        ctrl_o.reg_dst   = 1'b1;
        ctrl_o.reg_write = 1'b1;
        case (funct_i)
          FN_ADD:  ctrl_o.alu_op = ALU_ADD;
          FN_SUB:  ctrl_o.alu_op = ALU_SUB;
          FN_AND:  ctrl_o.alu_op = ALU_AND;
          FN_OR:   ctrl_o.alu_op = ALU_OR;
          FN_SLT:  ctrl_o.alu_op = ALU_SLT;
          default: ctrl_o.reg_write = 1'b0;
        endcase
      end
      OP_ADDI: begin
        ctrl_o.alu_src   = 1'b1;
        ctrl_o.reg_write = 1'b1;
      end
      OP_LW: begin
        ctrl_o.alu_src    = 1'b1;
        ctrl_o.mem_read   = 1'b1;
        ctrl_o.mem_to_reg = 1'b1;
        ctrl_o.reg_write  = 1'b1;
      end
      OP_SW: begin
        ctrl_o.alu_src   = 1'b1;
        ctrl_o.mem_write = 1'b1;
      end
      OP_BEQ, OP_BNE: begin
        ctrl_o.branch = 1'b1;
        ctrl_o.br_ne  = (opcode_i == OP_BNE);
        ctrl_o.alu_op = ALU_SUB;
      end
      default: ;
    endcase
  end

  always_comb begin
    if (ctrl_o.mem_write) p_store_no_wb_r5: assert (!ctrl_o.reg_write);
    if (ctrl_o.mem_to_reg) p_load_reads_r4: assert (ctrl_o.mem_read && ctrl_o.alu_src);
    if (ctrl_o.branch) p_branch_quiet_r6: assert (!ctrl_o.reg_write && !ctrl_o.mem_write);
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] res_o,
  output logic         zero_o
);
  always_comb begin
    case (op_i)
      ALU_AND: res_o = a_i & b_i;
      ALU_OR:  res_o = a_i | b_i;
      ALU_SUB: res_o = a_i - b_i;
      ALU_SLT: res_o = {{(W-1){1'b0}}, $signed(a_i) < $signed(b_i)};
      default: res_o = a_i + b_i;
    endcase
  end

  assign zero_o = (res_o == '0);

  always_comb begin
    if (op_i == ALU_SLT) p_slt_bool_r2: assert (res_o[W-1:1] == '0);
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W      = 32,
  parameter int NREGS  = 32,
  parameter int NRD    = 3,
  localparam int AW    = $clog2(NREGS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NRD-1:0][AW-1:0] raddr_i,
  output logic [NRD-1:0][W-1:0]  rdata_o,
  input  logic                   we_i,
  input  logic [AW-1:0]          waddr_i,
  input  logic [W-1:0]           wdata_i
);
  logic [W-1:0] rf_q [NREGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREGS; i++) rf_q[i] <= '0;
    end else if (we_i && waddr_i != '0) begin
      rf_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata_o[g] = (raddr_i[g] == '0) ? '0 : rf_q[raddr_i[g]];
  end

  p_r0_never_written_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_q[0] == '0);
  p_write_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i != '0) |=> rf_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6,
  parameter int NREGS   = 32,
  parameter int LD_AW   = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW,
  parameter int RAW     = $clog2(NREGS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ld_imem_we_i,
  input  logic            ld_dmem_we_i,
  input  logic [LD_AW-1:0] ld_addr_i,
  input  logic [31:0]     ld_data_i,
  input  logic [RAW-1:0]  dbg_reg_addr_i,
  output logic [31:0]     dbg_reg_data_o,
  input  logic [DMEM_AW-1:0] dbg_mem_addr_i,
  output logic [31:0]     dbg_mem_data_o,
  output logic [31:0]     pc_o
);
  localparam int IDEPTH = 2 ** IMEM_AW;
  localparam int DDEPTH = 2 ** DMEM_AW;

  logic [XLEN-1:0] imem [IDEPTH];
  logic [XLEN-1:0] dmem [DDEPTH];

  logic [XLEN-1:0] pc_q, pc_plus4, pc_next, br_off, imm_sx;
  logic [XLEN-1:0] instr, op_b, alu_res, mem_rdata, wb_data;
  logic            alu_zero, take_br;
  logic [RAW-1:0]  wr_reg;
  ctrl_t           ctrl;

  logic [2:0][RAW-1:0]  rf_raddr;
  logic [2:0][XLEN-1:0] rf_rdata;

  // fetch
  assign instr    = imem[pc_q[IMEM_AW+1:2]];
  assign pc_plus4 = pc_q + 32'd4;

  // decode
  sc_decoder u_dec (
    .opcode_i (instr[31:26]),
    .funct_i  (instr[5:0]),
    .ctrl_o   (ctrl)
  );

  assign imm_sx   = {{16{instr[15]}}, instr[15:0]};
  assign wr_reg   = ctrl.reg_dst ? instr[15:11] : instr[20:16];
  assign rf_raddr = {dbg_reg_addr_i, instr[20:16], instr[25:21]};

  sc_regfile #(.W(XLEN), .NREGS(NREGS), .NRD(3)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raddr_i (rf_raddr),
    .rdata_o (rf_rdata),
    .we_i    (ctrl.reg_write),
    .waddr_i (wr_reg),
    .wdata_i (wb_data)
  );

  // execute
  assign op_b = ctrl.alu_src ? imm_sx : rf_rdata[1];

  sc_alu #(.W(XLEN)) u_alu (
    .a_i    (rf_rdata[0]),
    .b_i    (op_b),
    .op_i   (ctrl.alu_op),
    .res_o  (alu_res),
    .zero_o (alu_zero)
  );

  // next pc: one zero flag serves both compare senses
  assign take_br = ctrl.branch & (alu_zero ^ ctrl.br_ne);
  assign br_off  = {imm_sx[XLEN-3:0], 2'b00};
  assign pc_next = take_br ? pc_plus4 + br_off : pc_plus4;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_next;
  end

  // memory
  assign mem_rdata = ctrl.mem_read ? dmem[alu_res[DMEM_AW+1:2]] : '0;
  assign wb_data   = ctrl.mem_to_reg ? mem_rdata : alu_res;

  always_ff @(posedge clk_i) begin
    if (ld_imem_we_i) imem[ld_addr_i[IMEM_AW-1:0]] <= ld_data_i;
  end

  always_ff @(posedge clk_i) begin
    if (ld_dmem_we_i)                dmem[ld_addr_i[DMEM_AW-1:0]] <= ld_data_i;
    else if (rst_ni && ctrl.mem_write) dmem[alu_res[DMEM_AW+1:2]] <= rf_rdata[1];
  end

  assign pc_o           = pc_q;
  assign dbg_reg_data_o = rf_rdata[2];
  assign dbg_mem_data_o = dmem[dbg_mem_addr_i];

  p_pc_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(take_br)) |-> pc_q == $past(pc_q) + 32'd4);
  p_br_target_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(take_br)) |-> pc_q == $past(pc_q) + 32'd4 + $past(br_off));
  p_pc_aligned_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_q[1:0] == 2'b00);
  p_bne_sense_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.branch && ctrl.br_ne && rf_rdata[0] == rf_rdata[1]) |=> pc_q == $past(pc_q) + 32'd4);
endmodule

// File: tb/sim_sc_core.sv
module sim_sc_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_i_we = 1'b0, ld_d_we = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_data;
  logic [5:0]  mem_addr = '0;
  logic [31:0] mem_data;
  logic [31:0] pc;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sc_core u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .ld_imem_we_i(ld_i_we), .ld_dmem_we_i(ld_d_we),
    .ld_addr_i(ld_addr), .ld_data_i(ld_data),
    .dbg_reg_addr_i(reg_addr), .dbg_reg_data_o(reg_data),
    .dbg_mem_addr_i(mem_addr), .dbg_mem_data_o(mem_data),
    .pc_o(pc)
  );

  function automatic logic [31:0] rt_op(input logic [4:0] rd, rs, rt, input logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction
  function automatic logic [31:0] it_op(input logic [5:0] op, input logic [4:0] rt, rs,
                                        input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  task automatic check(input string req, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ld_word(input bit to_imem, input int idx, input logic [31:0] val);
    @(negedge clk);
    ld_i_we = to_imem; ld_d_we = !to_imem;
    ld_addr = 6'(idx); ld_data = val;
    @(negedge clk);
    ld_i_we = 1'b0; ld_d_we = 1'b0;
  endtask

  task automatic run(input int cycles);
    @(negedge clk); rst_n = 1'b1;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic rd_reg(input int r, output logic [31:0] v);
    reg_addr = 5'(r); #1 v = reg_data;
  endtask
  task automatic rd_mem(input int a, output logic [31:0] v);
    mem_addr = 6'(a); #1 v = mem_data;
  endtask

  localparam logic [31:0] HALT = 32'h1000FFFF; // beq r0,r0,-1

  initial begin
    logic [31:0] v;
    logic [31:0] vals [8] = '{32'h0, 32'h1, 32'h5, 32'h7FFFFFFF, 32'h80000000,
                              32'hFFFFFFFF, 32'h12345678, 32'hFFFFFFF0};
    // R11: memory load while in reset
    ld_word(1, 0,  it_op(6'h23, 5'd1, 5'd0, 16'd0));   // lw r1,0(r0)
    ld_word(1, 1,  it_op(6'h23, 5'd2, 5'd0, 16'd4));   // lw r2,4(r0)
    ld_word(1, 2,  rt_op(5'd3, 5'd1, 5'd2, 6'h20));
    ld_word(1, 3,  rt_op(5'd4, 5'd1, 5'd2, 6'h22));
    ld_word(1, 4,  rt_op(5'd5, 5'd1, 5'd2, 6'h24));
    ld_word(1, 5,  rt_op(5'd6, 5'd1, 5'd2, 6'h25));
    ld_word(1, 6,  rt_op(5'd7, 5'd1, 5'd2, 6'h2A));
    ld_word(1, 7,  it_op(6'h08, 5'd8, 5'd1, 16'hFFFB)); // addi r8,r1,-5
    ld_word(1, 8,  it_op(6'h2B, 5'd3, 5'd0, 16'd8));    // sw r3,8(r0)
    ld_word(1, 9,  it_op(6'h23, 5'd9, 5'd0, 16'd8));    // lw r9,8(r0)
    ld_word(1, 10, it_op(6'h2B, 5'd4, 5'd0, 16'd12));   // sw r4,12(r0)
    ld_word(1, 11, HALT);

    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        logic [31:0] a, b;
        a = vals[i]; b = vals[j];
        rst_n = 1'b0;
        ld_word(0, 0, a);
        ld_word(0, 1, b);
        rd_mem(0, v); check("R11", v, a);
        rd_reg(3, v); check("R1", v, 32'h0);
        check("R1", pc, 32'h0);
        run(1);
        check("R9", pc, 32'd4);
        repeat (14) @(negedge clk);
        rd_reg(3, v); check("R2 add", v, a + b);
        rd_reg(4, v); check("R2 sub", v, a - b);
        rd_reg(5, v); check("R2 and", v, a & b);
        rd_reg(6, v); check("R2 or", v, a | b);
        rd_reg(7, v); check("R2 slt", v, ($signed(a) < $signed(b)) ? 32'd1 : 32'd0);
        rd_reg(8, v); check("R3", v, a - 32'd5);
        rd_reg(9, v); check("R4", v, a + b);
        rd_mem(2, v); check("R5", v, a + b);
        rd_mem(3, v); check("R5", v, a - b);
        check("R6 halt", pc, 32'd44);
      end
    end

    // branch / r0 / unknown-op program
    rst_n = 1'b0;
    ld_word(1, 0,  it_op(6'h08, 5'd1, 5'd0, 16'd5));
    ld_word(1, 1,  it_op(6'h08, 5'd2, 5'd0, 16'd5));
    ld_word(1, 2,  it_op(6'h04, 5'd2, 5'd1, 16'd2));   // beq taken -> 20
    ld_word(1, 3,  it_op(6'h08, 5'd3, 5'd0, 16'd1));
    ld_word(1, 4,  it_op(6'h08, 5'd3, 5'd0, 16'd2));
    ld_word(1, 5,  it_op(6'h05, 5'd2, 5'd1, 16'd1));   // bne not taken
    ld_word(1, 6,  it_op(6'h08, 5'd4, 5'd0, 16'd7));
    ld_word(1, 7,  it_op(6'h05, 5'd0, 5'd1, 16'd1));   // bne taken -> 36
    ld_word(1, 8,  it_op(6'h08, 5'd5, 5'd0, 16'd9));
    ld_word(1, 9,  it_op(6'h04, 5'd0, 5'd1, 16'd1));   // beq not taken
    ld_word(1, 10, it_op(6'h08, 5'd6, 5'd0, 16'd3));
    ld_word(1, 11, it_op(6'h08, 5'd0, 5'd0, 16'd9));   // write r0
    ld_word(1, 12, rt_op(5'd7, 5'd0, 5'd1, 6'h20));    // r7 = r0 + r1
    ld_word(1, 13, 32'hFC2800FF);                      // unknown opcode
    ld_word(1, 14, rt_op(5'd8, 5'd1, 5'd1, 6'h3F));    // unknown funct
    ld_word(1, 15, HALT);
    run(3);
    check("R6 beq taken", pc, 32'd20);
    run(30);
    rd_reg(3, v); check("R6 skipped", v, 32'h0);
    rd_reg(4, v); check("R7 not taken", v, 32'd7);
    rd_reg(5, v); check("R7 taken skip", v, 32'h0);
    rd_reg(6, v); check("R6 not taken", v, 32'd3);
    rd_reg(0, v); check("R8 r0", v, 32'h0);
    rd_reg(7, v); check("R8 r0 operand", v, 32'd5);
    rd_reg(8, v); check("R10 funct", v, 32'h0);
    rd_mem(2, v); check("R10 mem", v, vals[7] + vals[7]);
    check("R9 halt", pc, 32'd60);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule